// File: doc/BRIEF.md
# Dual Byte FIFO with Watermark and Trailing Events

This block sits between a register-bus slave and a serial bus engine and holds two byte queues. Outbound bytes are written by the register side into the transmit queue and drained by the engine. Inbound bytes are pushed by the engine into the receive queue and read back by the register side. Both queues are 64 bytes deep by default.

A 32-bit control word, driven from a register the decoder owns, enables each direction and sets a trigger level per direction. A 32-bit status word reports the level, full and empty state of both queues. Seven event lines go to an interrupt block:
- two level-type watermark events;
- a trailing-data event for receive bytes that sit below the trigger;
- four sticky error flags, one overrun and one underrun per direction.

The engine supplies a one-cycle strobe per serial bit period. This strobe times the trailing event. A soft-clear input empties both queues and clears every flag.

Top module: `dual_byte_fifo`

## Requirements
- R1: Each queue holds up to 64 bytes in first-in first-out order. An accepted push raises the level by one and an accepted pop lowers it by one. An accepted push and an accepted pop in the same cycle leave the level unchanged. The head byte of a non-empty queue is presented combinationally: `tx_pdata` for transmit, `rx_rdata` for receive.
- R2: Control word bit 0 enables the receive queue and bit 1 enables the transmit queue. Bits 10:4 hold the receive trigger level. Bits 22:16 hold the transmit trigger level.
- R3: The status word is laid out as follows:
  - bits 6:0: transmit level;
  - bit 7: transmit full;
  - bit 8: transmit empty;
  - bits 22:16: receive level;
  - bit 23: receive full;
  - bit 24: receive empty;
  - all other bits: zero.
  
  Full means a level of 64, and full and empty are never both set.
- R4: `ev_tx_aempty` is high while transmit is enabled and the transmit level is less than or equal to the transmit trigger.
- R5: `ev_rx_afull` is high while receive is enabled and the receive level is greater than or equal to the receive trigger.
- R6: A push to a full, enabled queue is dropped and sets that direction's sticky overrun flag, unless an accepted pop happens in the same cycle. In that case the push is accepted and the level stays at 64.
- R7: A pop from an empty, enabled queue leaves the level at 0 and sets that direction's sticky underrun flag. The data output of an empty queue reads zero. A push to the same queue in that cycle is still accepted.
- R8: The trailing event depends on an idle count of bit strobes.
  - The count restarts at zero on every accepted receive push, and whenever the receive queue is empty.
  - Otherwise it advances once per `bit_tick` and saturates at 15.
  - `ev_trailing` is high while receive is enabled, the queue is non-empty, `trail_limit` is non-zero and the count is at least `trail_limit`.
- R9: While a direction is disabled, its pushes and pops have no effect. They do not change its level and do not set its flags, and its watermark event is held low.
- R10: A cycle with `soft_clr` high empties both queues and clears all four sticky flags. This takes priority over any push or pop in the same cycle.
- R11: After reset both queues are empty, the status word reads 0x01000100 and all sticky flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_clr | input | 1 | Synchronous clear of both queues and all flags |
| cfg_word | input | 32 | Enables and trigger levels |
| trail_limit | input | 4 | Idle bit periods before the trailing event |
| bit_tick | input | 1 | One pulse per serial bit period |
| tx_wr | input | 1 | Register side writes a transmit byte |
| tx_wdata | input | 8 | Transmit byte to write |
| rx_rd | input | 1 | Register side reads a receive byte |
| rx_rdata | output | 8 | Receive head byte, zero when empty |
| tx_pop | input | 1 | Engine takes a transmit byte |
| tx_pdata | output | 8 | Transmit head byte, zero when empty |
| rx_push | input | 1 | Engine delivers a receive byte |
| rx_pdata | input | 8 | Receive byte delivered by the engine |
| status_word | output | 32 | Levels, full and empty of both queues |
| ev_tx_aempty | output | 1 | Transmit at or below its trigger |
| ev_rx_afull | output | 1 | Receive at or above its trigger |
| ev_trailing | output | 1 | Receive data left idle too long |
| ev_tx_ovr | output | 1 | Sticky transmit overrun |
| ev_tx_udr | output | 1 | Sticky transmit underrun |
| ev_rx_ovr | output | 1 | Sticky receive overrun |
| ev_rx_udr | output | 1 | Sticky receive underrun |

## Verification
The case of interest is a push and a pop on the same queue in the same cycle at either boundary. On a full queue the push must land because the pop frees a slot. On an empty queue the pop must underrun and return zero while the push still lands. The bench drives both strobes together on a queue held exactly at 64 and again at 0. It checks the level, the head byte and which sticky flag rose against a queue-based model. A long randomized phase then keeps producing such collisions, along with soft clears that coincide with traffic.

// File: rtl/dbf_pkg.sv
package dbf_pkg;
  // control word positions (decoded by the register neighbour)
  localparam int RX_EN_BIT    = 0;
  localparam int TX_EN_BIT    = 1;
  localparam int RX_TRIG_LSB  = 4;
  localparam int TX_TRIG_LSB  = 16;
  // status word positions
  localparam int ST_TX_LVL_LSB = 0;
  localparam int ST_TX_FULL    = 7;
  localparam int ST_TX_EMPTY   = 8;
  localparam int ST_RX_LVL_LSB = 16;
  localparam int ST_RX_FULL    = 23;
  localparam int ST_RX_EMPTY   = 24;
  // direction indices
  localparam int DIR_TX = 0;
  localparam int DIR_RX = 1;
endpackage

// File: rtl/dbf_fifo.sv
module dbf_fifo #(
  parameter  int DEPTH = 64,
  parameter  int DW    = 8,
  localparam int AW    = $clog2(DEPTH),
  localparam int LW    = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          en,
  input  logic          push,
  input  logic [DW-1:0] wdata,
  input  logic          pop,
  output logic [DW-1:0] head,
  output logic [LW-1:0] level,
  output logic          full,
  output logic          empty,
  output logic          ovr,
  output logic          udr,
  output logic          push_ok
);
  logic [AW-1:0] wptr_q, wptr_d, rptr_q, rptr_d;
  logic [LW-1:0] lvl_q, lvl_d;
  logic          ovr_q, ovr_d, udr_q, udr_d;
  logic [DW-1:0] mem [DEPTH];
  logic          pop_ok;

  assign full    = (lvl_q == LW'(DEPTH));
  assign empty   = (lvl_q == '0);
  assign pop_ok  = en && pop && !empty;
  assign push_ok = en && push && (!full || pop_ok);

  always_comb begin
    wptr_d = wptr_q;
    rptr_d = rptr_q;
    lvl_d  = lvl_q;
    ovr_d  = ovr_q | (en && push && !push_ok);
    udr_d  = udr_q | (en && pop && empty);
    if (clr) begin
      wptr_d = '0;
      rptr_d = '0;
      lvl_d  = '0;
      ovr_d  = 1'b0;
      udr_d  = 1'b0;
    end else begin
      if (push_ok) wptr_d = wptr_q + AW'(1);
      if (pop_ok)  rptr_d = rptr_q + AW'(1);
      case ({push_ok, pop_ok})
        2'b10:   lvl_d = lvl_q + LW'(1);
        2'b01:   lvl_d = lvl_q - LW'(1);
        default: lvl_d = lvl_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      lvl_q  <= '0;
      ovr_q  <= 1'b0;
      udr_q  <= 1'b0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      lvl_q  <= lvl_d;
      ovr_q  <= ovr_d;
      udr_q  <= udr_d;
    end
  end

  // storage array: no reset, written only under its enable
  always_ff @(posedge clk) begin
    if (push_ok && !clr) mem[wptr_q] <= wdata;
  end

  assign head  = empty ? '0 : mem[rptr_q];
  assign level = lvl_q;
  assign ovr   = ovr_q;
  assign udr   = udr_q;
endmodule

// File: rtl/dbf_trail.sv
module dbf_trail #(
  parameter int CNTW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            en,
  input  logic            tick,
  input  logic            push_ok,
  input  logic            empty,
  input  logic [CNTW-1:0] limit,
  output logic            trailing
);
  logic [CNTW-1:0] idle_q, idle_d;

  always_comb begin
    idle_d = idle_q;
    if (clr || push_ok || empty) idle_d = '0;
    else if (tick && (idle_q != '1)) idle_d = idle_q + CNTW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idle_q <= '0;
    else        idle_q <= idle_d;
  end

  assign trailing = en && !empty && (limit != '0) && (idle_q >= limit);
endmodule

// File: rtl/dual_byte_fifo.sv
module dual_byte_fifo
  import dbf_pkg::*;
#(
  parameter  int DEPTH = 64,
  parameter  int DW    = 8,
  parameter  int TRLW  = 4,
  localparam int LW    = $clog2(DEPTH) + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            soft_clr,
  input  logic [31:0]     cfg_word,
  input  logic [TRLW-1:0] trail_limit,
  input  logic            bit_tick,
  input  logic            tx_wr,
  input  logic [DW-1:0]   tx_wdata,
  input  logic            rx_rd,
  output logic [DW-1:0]   rx_rdata,
  input  logic            tx_pop,
  output logic [DW-1:0]   tx_pdata,
  input  logic            rx_push,
  input  logic [DW-1:0]   rx_pdata,
  output logic [31:0]     status_word,
  output logic            ev_tx_aempty,
  output logic            ev_rx_afull,
  output logic            ev_trailing,
  output logic            ev_tx_ovr,
  output logic            ev_tx_udr,
  output logic            ev_rx_ovr,
  output logic            ev_rx_udr
);
  // reset: asserted asynchronously, released through two flops
  logic [1:0] rsync_q;
  logic       rst_s_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_s_n = rsync_q[1];

  logic [1:0]    en_v, push_v, pop_v, full_v, empty_v, ovr_v, udr_v, pok_v;
  logic [DW-1:0] wdat_v [2];
  logic [DW-1:0] head_v [2];
  logic [LW-1:0] lvl_v  [2];
  logic [LW-1:0] tx_trig, rx_trig;

  assign en_v[DIR_TX]   = cfg_word[TX_EN_BIT];
  assign en_v[DIR_RX]   = cfg_word[RX_EN_BIT];
  assign push_v[DIR_TX] = tx_wr;
  assign push_v[DIR_RX] = rx_push;
  assign pop_v[DIR_TX]  = tx_pop;
  assign pop_v[DIR_RX]  = rx_rd;
  assign wdat_v[DIR_TX] = tx_wdata;
  assign wdat_v[DIR_RX] = rx_pdata;
  assign tx_trig        = cfg_word[TX_TRIG_LSB +: LW];
  assign rx_trig        = cfg_word[RX_TRIG_LSB +: LW];

  for (genvar g = 0; g < 2; g++) begin : g_dir
    dbf_fifo #(.DEPTH(DEPTH), .DW(DW)) u_fifo (
      .clk     (clk),
      .rst_n   (rst_s_n),
      .clr     (soft_clr),
      .en      (en_v[g]),
      .push    (push_v[g]),
      .wdata   (wdat_v[g]),
      .pop     (pop_v[g]),
      .head    (head_v[g]),
      .level   (lvl_v[g]),
      .full    (full_v[g]),
      .empty   (empty_v[g]),
      .ovr     (ovr_v[g]),
      .udr     (udr_v[g]),
      .push_ok (pok_v[g])
    );
  end

  dbf_trail #(.CNTW(TRLW)) u_trail (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .clr      (soft_clr),
    .en       (en_v[DIR_RX]),
    .tick     (bit_tick),
    .push_ok  (pok_v[DIR_RX]),
    .empty    (empty_v[DIR_RX]),
    .limit    (trail_limit),
    .trailing (ev_trailing)
  );

  always_comb begin
    status_word = '0;
    status_word[ST_TX_LVL_LSB +: LW] = lvl_v[DIR_TX];
    status_word[ST_TX_FULL]          = full_v[DIR_TX];
    status_word[ST_TX_EMPTY]         = empty_v[DIR_TX];
    status_word[ST_RX_LVL_LSB +: LW] = lvl_v[DIR_RX];
    status_word[ST_RX_FULL]          = full_v[DIR_RX];
    status_word[ST_RX_EMPTY]         = empty_v[DIR_RX];
  end

  assign tx_pdata     = head_v[DIR_TX];
  assign rx_rdata     = head_v[DIR_RX];
  assign ev_tx_aempty = en_v[DIR_TX] && (lvl_v[DIR_TX] <= tx_trig);
  assign ev_rx_afull  = en_v[DIR_RX] && (lvl_v[DIR_RX] >= rx_trig);
  assign ev_tx_ovr    = ovr_v[DIR_TX];
  assign ev_tx_udr    = udr_v[DIR_TX];
  assign ev_rx_ovr    = ovr_v[DIR_RX];
  assign ev_rx_udr    = udr_v[DIR_RX];
endmodule

// File: rtl/dbf_chk.sv
module dbf_chk
  import dbf_pkg::*;
#(
  parameter  int DEPTH = 64,
  localparam int LW    = $clog2(DEPTH) + 1
) (
  input logic        clk,
  input logic        rst_n,
  input logic        soft_clr,
  input logic [31:0] status_word,
  input logic [7:0]  rx_rdata,
  input logic        ev_trailing,
  input logic        ev_tx_ovr,
  input logic        ev_tx_udr,
  input logic        ev_rx_ovr,
  input logic        ev_rx_udr
);
  logic [LW-1:0] tx_l, rx_l;
  assign tx_l = status_word[ST_TX_LVL_LSB +: LW];
  assign rx_l = status_word[ST_RX_LVL_LSB +: LW];

  p_level_cap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_l <= LW'(DEPTH)) && (rx_l <= LW'(DEPTH)));

  p_level_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !soft_clr |=> ((tx_l == $past(tx_l)) || (tx_l == $past(tx_l) + LW'(1)) || (tx_l + LW'(1) == $past(tx_l))));

  p_full_not_empty_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(status_word[ST_TX_FULL] && status_word[ST_TX_EMPTY]) && !(status_word[ST_RX_FULL] && status_word[ST_RX_EMPTY]));

  p_tx_ovr_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_tx_ovr && !soft_clr |=> ev_tx_ovr);

  p_rx_ovr_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rx_ovr && !soft_clr |=> ev_rx_ovr);

  p_udr_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_tx_udr || ev_rx_udr) && !soft_clr |=> (ev_tx_udr || ev_rx_udr));

  p_empty_reads_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    status_word[ST_RX_EMPTY] |-> (rx_rdata == 8'h00));

  p_trail_has_data_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_trailing |-> !status_word[ST_RX_EMPTY]);

  p_soft_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    soft_clr |=> (status_word == 32'h0100_0100) && !ev_tx_ovr && !ev_tx_udr && !ev_rx_ovr && !ev_rx_udr);
endmodule

bind dual_byte_fifo dbf_chk #(.DEPTH(DEPTH)) u_dbf_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .soft_clr    (soft_clr),
  .status_word (status_word),
  .rx_rdata    (rx_rdata),
  .ev_trailing (ev_trailing),
  .ev_tx_ovr   (ev_tx_ovr),
  .ev_tx_udr   (ev_tx_udr),
  .ev_rx_ovr   (ev_rx_ovr),
  .ev_rx_udr   (ev_rx_udr)
);

// File: tb/dual_byte_fifo_tb_top.sv
`timescale 1ns/1ps
module dual_byte_fifo_tb_top;
  logic        clk = 1'b0;
  logic        rst_n, soft_clr, bit_tick, tx_wr, rx_rd, tx_pop, rx_push;
  logic [31:0] cfg_word;
  logic [3:0]  trail_limit;
  logic [7:0]  tx_wdata, rx_pdata, rx_rdata, tx_pdata;
  logic [31:0] status_word;
  logic        ev_tx_aempty, ev_rx_afull, ev_trailing, ev_tx_ovr, ev_tx_udr, ev_rx_ovr, ev_rx_udr;

  always #10 clk = ~clk;

  dual_byte_fifo dut_i (
    .clk(clk), .rst_n(rst_n), .soft_clr(soft_clr), .cfg_word(cfg_word),
    .trail_limit(trail_limit), .bit_tick(bit_tick),
    .tx_wr(tx_wr), .tx_wdata(tx_wdata), .rx_rd(rx_rd), .rx_rdata(rx_rdata),
    .tx_pop(tx_pop), .tx_pdata(tx_pdata), .rx_push(rx_push), .rx_pdata(rx_pdata),
    .status_word(status_word), .ev_tx_aempty(ev_tx_aempty), .ev_rx_afull(ev_rx_afull),
    .ev_trailing(ev_trailing), .ev_tx_ovr(ev_tx_ovr), .ev_tx_udr(ev_tx_udr),
    .ev_rx_ovr(ev_rx_ovr), .ev_rx_udr(ev_rx_udr)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  task automatic chk(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [7:0] txq[$];
  logic [7:0] rxq[$];
  bit m_txo, m_txu, m_rxo, m_rxu;
  int m_idle;

  function automatic logic [31:0] m_status();
    logic [31:0] s;
    s = '0;
    s[6:0]   = 7'(txq.size());
    s[7]     = (txq.size() == 64);
    s[8]     = (txq.size() == 0);
    s[22:16] = 7'(rxq.size());
    s[23]    = (rxq.size() == 64);
    s[24]    = (rxq.size() == 0);
    return s;
  endfunction

  always @(negedge clk) begin
    bit txen, rxen, tpok, twok, rpok, rwok;
    txen = cfg_word[1];
    rxen = cfg_word[0];
    if (rst_n) begin
      chk("R3 status word", status_word, m_status());
      chk("R1 tx head", tx_pdata, (txq.size() > 0) ? txq[0] : 8'h00);
      chk("R1 rx head", rx_rdata, (rxq.size() > 0) ? rxq[0] : 8'h00);
      chk("R4 tx almost-empty", ev_tx_aempty, txen && (txq.size() <= int'(cfg_word[22:16])));
      chk("R5 rx almost-full", ev_rx_afull, rxen && (rxq.size() >= int'(cfg_word[10:4])));
      chk("R8 trailing", ev_trailing, rxen && (rxq.size() > 0) && (trail_limit != 0) && (m_idle >= int'(trail_limit)));
      chk("R6 tx overrun", ev_tx_ovr, m_txo);
      chk("R6 rx overrun", ev_rx_ovr, m_rxo);
      chk("R7 tx underrun", ev_tx_udr, m_txu);
      chk("R7 rx underrun", ev_rx_udr, m_rxu);
    end
    // advance model to the coming edge
    if (!rst_n || soft_clr) begin
      txq.delete(); rxq.delete();
      m_txo = 0; m_txu = 0; m_rxo = 0; m_rxu = 0; m_idle = 0;
    end else begin
      tpok = txen && tx_pop && (txq.size() > 0);
      twok = txen && tx_wr && ((txq.size() < 64) || tpok);
      rpok = rxen && rx_rd && (rxq.size() > 0);
      rwok = rxen && rx_push && ((rxq.size() < 64) || rpok);
      if (txen && tx_wr && !twok) m_txo = 1;
      if (txen && tx_pop && txq.size() == 0) m_txu = 1;
      if (rxen && rx_push && !rwok) m_rxo = 1;
      if (rxen && rx_rd && rxq.size() == 0) m_rxu = 1;
      if (rwok || rxq.size() == 0) m_idle = 0;
      else if (bit_tick && m_idle < 15) m_idle++;
      if (tpok) void'(txq.pop_front());
      if (twok) txq.push_back(tx_wdata);
      if (rpok) void'(rxq.pop_front());
      if (rwok) rxq.push_back(rx_pdata);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic drive(input logic tw, input logic [7:0] td, input logic tp,
                       input logic rp, input logic [7:0] rd, input logic rr,
                       input logic tk, input logic sc);
    @(posedge clk); #2;
    tx_wr = tw; tx_wdata = td; tx_pop = tp;
    rx_push = rp; rx_pdata = rd; rx_rd = rr;
    bit_tick = tk; soft_clr = sc;
  endtask

  task automatic look();
    drive(0, 8'h00, 0, 0, 8'h00, 0, 0, 0);
    @(negedge clk); #1;
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog R1 act=hung exp=finished");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 0; soft_clr = 0; bit_tick = 0; tx_wr = 0; rx_rd = 0; tx_pop = 0; rx_push = 0;
    tx_wdata = 0; rx_pdata = 0; cfg_word = 32'h0; trail_limit = 4'd4;
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    repeat (4) look();
    chk("R11 status after reset", status_word, 32'h0100_0100);
    chk("R11 flags after reset", {ev_tx_ovr, ev_tx_udr, ev_rx_ovr, ev_rx_udr}, 0);

    // both enabled, rx trigger 8, tx trigger 2
    cfg_word = 32'h0002_0083;
    look();
    chk("R4 empty tx below trigger", ev_tx_aempty, 1);
    for (int i = 0; i < 5; i++) drive(1, 8'hA0 + 8'(i), 0, 0, 0, 0, 0, 0);
    look();
    chk("R3 five tx bytes", status_word, 32'h0100_0005);
    chk("R4 above trigger", ev_tx_aempty, 0);
    chk("R1 tx order head", tx_pdata, 8'hA0);
    repeat (3) drive(0, 0, 1, 0, 0, 0, 0, 0);
    look();
    chk("R4 at trigger", ev_tx_aempty, 1);
    chk("R1 tx order after pops", tx_pdata, 8'hA3);
    repeat (2) drive(0, 0, 1, 0, 0, 0, 0, 0);
    drive(0, 0, 1, 0, 0, 0, 0, 0);
    look();
    chk("R7 tx underrun set", ev_tx_udr, 1);
    chk("R7 empty tx reads zero", tx_pdata, 8'h00);
    drive(1, 8'h5A, 1, 0, 0, 0, 0, 0);
    look();
    chk("R7 push lands beside empty pop", status_word[6:0], 1);
    chk("R7 landed byte", tx_pdata, 8'h5A);
    drive(0, 0, 1, 0, 0, 0, 0, 0);

    for (int i = 0; i < 64; i++) drive(1, 8'(i), 0, 0, 0, 0, 0, 0);
    look();
    chk("R3 tx full word", status_word, 32'h0100_00C0);
    chk("R6 no overrun yet", ev_tx_ovr, 0);
    drive(1, 8'hEE, 0, 0, 0, 0, 0, 0);
    look();
    chk("R6 tx overrun", ev_tx_ovr, 1);
    chk("R6 level held", status_word[6:0], 64);
    drive(1, 8'hEF, 1, 0, 0, 0, 0, 0);
    look();
    chk("R6 write with pop on full", status_word[6:0], 64);
    chk("R6 head after pop", tx_pdata, 8'h01);

    // receive side
    for (int i = 0; i < 7; i++) drive(0, 0, 0, 1, 8'hB0 + 8'(i), 0, 0, 0);
    look();
    chk("R5 below rx trigger", ev_rx_afull, 0);
    drive(0, 0, 0, 1, 8'hB7, 0, 0, 0);
    look();
    chk("R2 rx trigger field at bit 4", ev_rx_afull, 1);
    chk("R1 rx head", rx_rdata, 8'hB0);
    drive(0, 0, 0, 0, 0, 1, 0, 0);
    look();
    chk("R5 drop below trigger", ev_rx_afull, 0);

    // trailing with limit 4
    repeat (3) drive(0, 0, 0, 0, 0, 0, 1, 0);
    look();
    chk("R8 three idle periods", ev_trailing, 0);
    drive(0, 0, 0, 0, 0, 0, 1, 0);
    look();
    chk("R8 four idle periods", ev_trailing, 1);
    drive(0, 0, 0, 1, 8'hC0, 0, 0, 0);
    look();
    chk("R8 push restarts count", ev_trailing, 0);

    for (int i = 0; i < 56; i++) drive(0, 0, 0, 1, 8'(i), 0, 0, 0);
    look();
    chk("R3 rx full", status_word[24:16], 9'h0C0);
    drive(0, 0, 0, 1, 8'hDD, 0, 0, 0);
    look();
    chk("R6 rx overrun", ev_rx_ovr, 1);

    // soft clear racing traffic
    drive(1, 8'h11, 1, 1, 8'h22, 1, 1, 1);
    look();
    chk("R10 status cleared", status_word, 32'h0100_0100);
    chk("R10 flags cleared", {ev_tx_ovr, ev_tx_udr, ev_rx_ovr, ev_rx_udr}, 0);

    // receive disabled
    cfg_word = 32'h0002_0082;
    repeat (3) drive(0, 0, 0, 1, 8'h33, 1, 0, 0);
    look();
    chk("R9 disabled rx level", status_word[22:16], 0);
    chk("R9 disabled rx flags", {ev_rx_ovr, ev_rx_udr, ev_rx_afull}, 0);
    cfg_word = 32'h0002_0083;
    drive(0, 0, 0, 1, 8'h44, 1, 0, 0);
    look();
    chk("R7 rx underrun with push", ev_rx_udr, 1);
    chk("R7 rx push lands", status_word[22:16], 1);

    // randomized traffic
    for (int blk = 0; blk < 12; blk++) begin
      int unsigned bias;
      bias = $urandom % 4;
      cfg_word = '0;
      cfg_word[0] = ($urandom % 5) != 0;
      cfg_word[1] = ($urandom % 5) != 0;
      cfg_word[10:4] = 7'($urandom % 65);
      cfg_word[22:16] = 7'($urandom % 65);
      trail_limit = 4'($urandom);
      for (int c = 0; c < 250; c++) begin
        logic tw, tp, rp, rr;
        tw = ($urandom % 4) < (bias + 1);
        tp = ($urandom % 4) < (4 - bias);
        rp = ($urandom % 4) < (bias + 1);
        rr = ($urandom % 4) < (4 - bias);
        drive(tw, 8'($urandom), tp, rp, 8'($urandom), rr,
              ($urandom % 2) == 0, ($urandom % 300) == 0);
      end
    end
    look();

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule